// File: doc/BRIEF.md
# Elastic-Store Jitter Attenuator

This block smooths the timing of a serial bit stream. Incoming bits, each qualified by a one-cycle strobe that may come irregularly (gapped or in bursts), are written into a one-bit-wide elastic store. A numerically controlled oscillator running on the oversampled master clock reads them back out with an evenly spaced strobe. The oscillator's step size is its nominal value (one output bit every `OSR` master cycles) plus a correction proportional to how far the store's fill level sits from its midpoint. This closes a slow first-order loop, so the average output rate follows the average input rate while short-term timing variation is absorbed.

Configuration inputs choose the store depth (deep or shallow), the line standard, and which of the two streams (receive or transmit) goes through the store. The line standard sets the loop gain and therefore the corner frequency. The stream that is not selected passes straight through. If the fill level moves too far from the midpoint, the store recentres and a sticky trip flag is raised. Software clears the flag by pulsing a clear input.

Top module: `jitter_atten`

## Requirements
- R1: While reset is asserted and on the first cycle after reset is released, `trip_o` is 0 and the strobe of the attenuated path (receive by default) is 0. Reset selects the deep store and receive placement, and fills the store to its midpoint with zero bits.
- R2: `cfg_place_i` = 2'b01 routes the receive stream through the store and 2'b10 routes the transmit stream through it. The path that is not selected gives out its input bit and strobe combinationally, in the same cycle.
- R3: Bits leave the store in the order they were written. After any recentring, the store first holds half its depth of zero bits, and these come out before any newly written bit.
- R4: The output strobe and output bit are registered and appear one cycle after the oscillator step that carries out. Two strobes are never on adjacent cycles. When the fill level sits at its midpoint, the oscillator step is 2^ACC_W/OSR.
- R5: The oscillator step is the nominal step plus (fill − midpoint)·2^K, where K = `T1_SHIFT` when `cfg_e1_i`=0 and K = `E1_SHIFT` when `cfg_e1_i`=1.
- R6: With the deep store (`cfg_deep_i`=1, 128 bits), a fill level that would move above midpoint+60 or below midpoint−60 recentres the store instead and sets the trip flag, so a 120-UI peak-to-peak excursion trips.
- R7: With the shallow store (`cfg_deep_i`=0, 32 bits), the limit is midpoint ±14, which is 28 UI peak-to-peak. This applies to both overflow and starvation.
- R8: The trip flag is sticky. A one-cycle pulse on `trip_clr_i` clears it, but a trip in the same cycle wins over the clear.
- R9: A change in depth or placement flushes the store and recentres it for the new depth. The output strobe is 0 on the following cycle. A change of line standard causes no flush.
- R10: With placement 2'b00 or 2'b11 both streams pass straight through. The store then neither fills nor drains, and no trip can occur.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Oversampled master clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_deep_i | input | 1 | 1 selects the 128-bit store, 0 the 32-bit store |
| cfg_e1_i | input | 1 | 1 selects E1 loop gain, 0 selects T1 |
| cfg_place_i | input | 2 | 01 receive, 10 transmit, 00/11 bypass |
| rx_bit_i | input | 1 | Receive data bit |
| rx_stb_i | input | 1 | Receive bit strobe |
| tx_bit_i | input | 1 | Transmit data bit |
| tx_stb_i | input | 1 | Transmit bit strobe |
| trip_clr_i | input | 1 | Write-1 pulse that clears the trip flag |
| rx_bit_o | output | 1 | Receive data bit out |
| rx_stb_o | output | 1 | Receive strobe out |
| tx_bit_o | output | 1 | Transmit data bit out |
| tx_stb_o | output | 1 | Transmit strobe out |
| trip_o | output | 1 | Sticky limit-trip flag |

## Verification
The bench builds the block with its default parameters: deep store 128, shallow store 32, OSR 8, a 16-bit accumulator and gain shifts of 6 (T1) and 3 (E1). With one output bit every eight cycles, a run of back-to-back input strobes overflows either depth within about 70 cycles. Withholding input starves the shallow store within a few hundred cycles. Both trip limits, recentring and the following stream of zero bits can therefore be reached in short runs. The small step size also keeps every oscillator step well below half the accumulator range, so the exact phase of the output strobe can be predicted cycle by cycle even at the extremes of the fill level.

// File: rtl/jatt_pkg.sv
package jatt_pkg;
  typedef enum logic [1:0] {
    PLACE_NONE = 2'b00,
    PLACE_RX   = 2'b01,
    PLACE_TX   = 2'b10,
    PLACE_OFF  = 2'b11
  } place_e;
endpackage

// File: rtl/ja_nco.sv
module ja_nco #(
  parameter int OSR      = 8,
  parameter int ACC_W    = 16,
  parameter int LVL_W    = 8,
  parameter int T1_SHIFT = 6,
  parameter int E1_SHIFT = 3
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    e1_i,
  input  logic signed [LVL_W:0]   fill_err_i,
  output logic                    tick_o
);
  localparam int NOM_INC = (1 << ACC_W) / OSR;

  logic [ACC_W-1:0]      acc_q;
  logic signed [ACC_W:0] err_x, inc;
  logic [ACC_W:0]        sum;

  always_comb begin
    err_x = {{(ACC_W-LVL_W){fill_err_i[LVL_W]}}, fill_err_i};
    inc   = (ACC_W+1)'(NOM_INC) + (e1_i ? (err_x <<< E1_SHIFT) : (err_x <<< T1_SHIFT));
    sum   = {1'b0, acc_q} + inc;
  end

  assign tick_o = sum[ACC_W];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) acc_q <= '0;
    else         acc_q <= sum[ACC_W-1:0];
  end

  AST_TICK_SPACED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |=> !tick_o);  // R4
endmodule

// File: rtl/ja_elastic.sv
module ja_elastic #(
  parameter int MAX_DEPTH     = 128,
  parameter int SHALLOW_DEPTH = 32,
  parameter int TRIP_DEEP     = 120,
  parameter int TRIP_SHALLOW  = 28,
  parameter int LVL_W         = $clog2(MAX_DEPTH) + 1
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  deep_i,
  input  logic                  deep_new_i,
  input  logic                  flush_i,
  input  logic                  enable_i,
  input  logic                  in_bit_i,
  input  logic                  in_stb_i,
  input  logic                  tick_i,
  output logic                  out_bit_o,
  output logic                  out_stb_o,
  output logic signed [LVL_W:0] fill_err_o,
  output logic                  trip_o
);
  localparam int PTR_W   = $clog2(MAX_DEPTH);
  localparam int C_DEEP  = MAX_DEPTH / 2;
  localparam int C_SHAL  = SHALLOW_DEPTH / 2;
  localparam int HI_DEEP = C_DEEP + TRIP_DEEP / 2;
  localparam int LO_DEEP = C_DEEP - TRIP_DEEP / 2;
  localparam int HI_SHAL = C_SHAL + TRIP_SHALLOW / 2;
  localparam int LO_SHAL = C_SHAL - TRIP_SHALLOW / 2;

  logic [MAX_DEPTH-1:0] mem_q;
  logic [PTR_W-1:0]     wr_q, rd_q, mask;
  logic [LVL_W-1:0]     lvl_q, ctr, ctr_new;
  logic [LVL_W:0]       lvl_nxt, hi, lo;
  logic                 out_bit_q, out_stb_q, wr_en, rd_en, trip;

  always_comb begin
    ctr     = deep_i     ? LVL_W'(C_DEEP) : LVL_W'(C_SHAL);
    ctr_new = deep_new_i ? LVL_W'(C_DEEP) : LVL_W'(C_SHAL);
    mask    = deep_i ? PTR_W'(MAX_DEPTH - 1) : PTR_W'(SHALLOW_DEPTH - 1);
    hi      = deep_i ? (LVL_W+1)'(HI_DEEP) : (LVL_W+1)'(HI_SHAL);
    lo      = deep_i ? (LVL_W+1)'(LO_DEEP) : (LVL_W+1)'(LO_SHAL);
    wr_en   = enable_i & in_stb_i;
    rd_en   = enable_i & tick_i;
    lvl_nxt = {1'b0, lvl_q} + {{LVL_W{1'b0}}, wr_en} - {{LVL_W{1'b0}}, rd_en};
    trip    = enable_i & ~flush_i & ((lvl_nxt > hi) | (lvl_nxt < lo));
  end

  assign fill_err_o = $signed({1'b0, lvl_q}) - $signed({1'b0, ctr});
  assign out_bit_o  = out_bit_q;
  assign out_stb_o  = out_stb_q;
  assign trip_o     = trip;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mem_q     <= '0;
      wr_q      <= PTR_W'(C_DEEP);
      rd_q      <= '0;
      lvl_q     <= LVL_W'(C_DEEP);
      out_bit_q <= 1'b0;
      out_stb_q <= 1'b0;
    end else if (flush_i) begin
      mem_q     <= '0;
      wr_q      <= PTR_W'(ctr_new);
      rd_q      <= '0;
      lvl_q     <= ctr_new;
      out_stb_q <= 1'b0;
    end else if (trip) begin
      mem_q     <= '0;
      wr_q      <= PTR_W'(ctr);
      rd_q      <= '0;
      lvl_q     <= ctr;
      out_stb_q <= 1'b0;
    end else begin
      out_stb_q <= rd_en;
      if (rd_en) begin
        out_bit_q <= mem_q[rd_q];
        rd_q      <= (rd_q + 1'b1) & mask;
      end
      if (wr_en) begin
        mem_q[wr_q] <= in_bit_i;
        wr_q        <= (wr_q + 1'b1) & mask;
      end
      lvl_q <= lvl_nxt[LVL_W-1:0];
    end
  end

  AST_FILL_DEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    deep_i |-> (lvl_q >= LVL_W'(LO_DEEP)) && (lvl_q <= LVL_W'(HI_DEEP)));  // R6
  AST_FILL_SHALLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !deep_i |-> (lvl_q >= LVL_W'(LO_SHAL)) && (lvl_q <= LVL_W'(HI_SHAL)));  // R7
  AST_FLUSH_RECENTER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> (lvl_q == ctr) && !out_stb_o);  // R9
  AST_BYPASS_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!enable_i && !flush_i) |=> $stable(lvl_q));  // R10
endmodule

// File: rtl/jitter_atten.sv
module jitter_atten
  import jatt_pkg::*;
#(
  parameter int MAX_DEPTH     = 128,
  parameter int SHALLOW_DEPTH = 32,
  parameter int TRIP_DEEP     = 120,
  parameter int TRIP_SHALLOW  = 28,
  parameter int OSR           = 8,
  parameter int ACC_W         = 16,
  parameter int T1_SHIFT      = 6,
  parameter int E1_SHIFT      = 3
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       cfg_deep_i,
  input  logic       cfg_e1_i,
  input  logic [1:0] cfg_place_i,
  input  logic       rx_bit_i,
  input  logic       rx_stb_i,
  input  logic       tx_bit_i,
  input  logic       tx_stb_i,
  input  logic       trip_clr_i,
  output logic       rx_bit_o,
  output logic       rx_stb_o,
  output logic       tx_bit_o,
  output logic       tx_stb_o,
  output logic       trip_o
);
  localparam int LVL_W = $clog2(MAX_DEPTH) + 1;

  place_e               place_q;
  logic                 deep_q, flush, enable, sel, trip_evt, trip_q;
  logic                 in_bit, in_stb, tick, out_bit, out_stb;
  logic signed [LVL_W:0] fill_err;
  logic [1:0]           src_bit, src_stb, dst_bit, dst_stb;

  assign flush  = (cfg_deep_i != deep_q) || (cfg_place_i != place_q);
  assign enable = (place_q == PLACE_RX) || (place_q == PLACE_TX);
  assign sel    = (place_q == PLACE_TX);
  assign in_bit = sel ? tx_bit_i : rx_bit_i;
  assign in_stb = sel ? tx_stb_i : rx_stb_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      deep_q  <= 1'b1;
      place_q <= PLACE_RX;
      trip_q  <= 1'b0;
    end else begin
      deep_q  <= cfg_deep_i;
      place_q <= place_e'(cfg_place_i);
      trip_q  <= (trip_q & ~trip_clr_i) | trip_evt;
    end
  end

  ja_elastic #(
    .MAX_DEPTH    (MAX_DEPTH),
    .SHALLOW_DEPTH(SHALLOW_DEPTH),
    .TRIP_DEEP    (TRIP_DEEP),
    .TRIP_SHALLOW (TRIP_SHALLOW),
    .LVL_W        (LVL_W)
  ) u_store (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .deep_i    (deep_q),
    .deep_new_i(cfg_deep_i),
    .flush_i   (flush),
    .enable_i  (enable),
    .in_bit_i  (in_bit),
    .in_stb_i  (in_stb),
    .tick_i    (tick),
    .out_bit_o (out_bit),
    .out_stb_o (out_stb),
    .fill_err_o(fill_err),
    .trip_o    (trip_evt)
  );

  ja_nco #(
    .OSR     (OSR),
    .ACC_W   (ACC_W),
    .LVL_W   (LVL_W),
    .T1_SHIFT(T1_SHIFT),
    .E1_SHIFT(E1_SHIFT)
  ) u_nco (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .e1_i      (cfg_e1_i),
    .fill_err_i(fill_err),
    .tick_o    (tick)
  );

  assign src_bit = {tx_bit_i, rx_bit_i};
  assign src_stb = {tx_stb_i, rx_stb_i};

  // index 0 = receive path, 1 = transmit path
  for (genvar p = 0; p < 2; p++) begin : g_path
    assign dst_bit[p] = (enable && sel == 1'(p)) ? out_bit : src_bit[p];
    assign dst_stb[p] = (enable && sel == 1'(p)) ? out_stb : src_stb[p];
  end

  assign rx_bit_o = dst_bit[0];
  assign rx_stb_o = dst_stb[0];
  assign tx_bit_o = dst_bit[1];
  assign tx_stb_o = dst_stb[1];
  assign trip_o   = trip_q;

  AST_TRIP_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trip_o && !trip_clr_i) |=> trip_o);  // R8
  AST_TRIP_LATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trip_evt |=> trip_o);  // R6
endmodule

// File: tb/jitter_atten_tb.sv
module jitter_atten_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_deep = 1'b1, cfg_e1 = 1'b0, trip_clr = 1'b0;
  logic [1:0] cfg_place = 2'b01;
  logic rx_bit = 1'b0, rx_stb = 1'b0, tx_bit = 1'b0, tx_stb = 1'b0;
  logic rx_bit_o, rx_stb_o, tx_bit_o, tx_stb_o, trip_o;

  int checks = 0, fails = 0;
  bit done = 1'b0;
  string cur_req = "R1";

  // behavioural reference state
  bit   q[$];
  int   acc_m = 0;
  bit   deep_m = 1'b1, flag_m = 1'b0, stb_m = 1'b0, bit_m = 1'b0;
  bit [1:0] place_m = 2'b01;

  always #10 clk = ~clk;

  jitter_atten u_dut (
    .clk_i(clk), .rst_ni(rst_n), .cfg_deep_i(cfg_deep), .cfg_e1_i(cfg_e1),
    .cfg_place_i(cfg_place), .rx_bit_i(rx_bit), .rx_stb_i(rx_stb),
    .tx_bit_i(tx_bit), .tx_stb_i(tx_stb), .trip_clr_i(trip_clr),
    .rx_bit_o(rx_bit_o), .rx_stb_o(rx_stb_o), .tx_bit_o(tx_bit_o),
    .tx_stb_o(tx_stb_o), .trip_o(trip_o)
  );

  function automatic int mid(bit d);
    return d ? 64 : 16;
  endfunction

  function automatic int half_lim(bit d);
    return d ? 60 : 14;
  endfunction

  task automatic recentre(bit d);
    q = {};
    repeat (mid(d)) q.push_back(1'b0);
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      recentre(1'b1);
      acc_m = 0; deep_m = 1'b1; place_m = 2'b01;
      flag_m = 1'b0; stb_m = 1'b0; bit_m = 1'b0;
    end else begin
      int err, inc, sum, nl;
      bit tick, trip_e, ib, is;
      err  = q.size() - mid(deep_m);
      inc  = 8192 + err * (cfg_e1 ? 8 : 64);
      sum  = acc_m + inc;
      tick = (sum >= 65536);
      acc_m = sum % 65536;
      trip_e = 1'b0;
      if (cfg_deep != deep_m || cfg_place != place_m) begin
        deep_m = cfg_deep; place_m = cfg_place;
        recentre(deep_m);
        stb_m = 1'b0;
      end else if (place_m == 2'b01 || place_m == 2'b10) begin
        ib = (place_m == 2'b10) ? tx_bit : rx_bit;
        is = (place_m == 2'b10) ? tx_stb : rx_stb;
        nl = q.size() + int'(is) - int'(tick);
        if (nl > mid(deep_m) + half_lim(deep_m) || nl < mid(deep_m) - half_lim(deep_m)) begin
          trip_e = 1'b1;
          recentre(deep_m);
          stb_m = 1'b0;
        end else begin
          stb_m = tick;
          if (tick) bit_m = q.pop_front();
          if (is) q.push_back(ib);
        end
      end else begin
        stb_m = 1'b0;
      end
      flag_m = (flag_m && !trip_clr) || trip_e;
    end
  end

  task automatic chk(bit act, bit exp, string req, string what);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0b expected %0b at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic compare();
    bit e_rs, e_rb, e_ts, e_tb;
    e_rs = (place_m == 2'b01) ? stb_m : rx_stb;
    e_rb = (place_m == 2'b01) ? bit_m : rx_bit;
    e_ts = (place_m == 2'b10) ? stb_m : tx_stb;
    e_tb = (place_m == 2'b10) ? bit_m : tx_bit;
    chk(rx_stb_o, e_rs, cur_req, "rx_stb");
    chk(rx_bit_o, e_rb, cur_req, "rx_bit");
    chk(tx_stb_o, e_ts, cur_req, "tx_stb");
    chk(tx_bit_o, e_tb, cur_req, "tx_bit");
    chk(trip_o, flag_m, cur_req, "trip");
  endtask

  bit clr_req = 1'b0;

  task automatic cyc(bit rs, bit rb, bit ts, bit tb);
    @(negedge clk);
    compare();
    rx_stb = rs; rx_bit = rb; tx_stb = ts; tx_bit = tb;
    trip_clr = clr_req; clr_req = 1'b0;
  endtask

  function automatic bit rnd();
    return 1'($urandom);
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual running expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(trip_o, 1'b0, "R1", "trip during reset");
    chk(rx_stb_o, 1'b0, "R1", "rx_stb during reset");
    rst_n = 1'b1;
    @(negedge clk);
    chk(trip_o, 1'b0, "R1", "trip after reset");
    chk(rx_stb_o, 1'b0, "R1", "rx_stb after reset");

    cur_req = "R4";  // steady receive input
    for (int i = 0; i < 400; i++) cyc(i % 8 == 0, rnd(), rnd(), rnd());

    cur_req = "R3";  // bursty receive input, same average rate
    for (int i = 0; i < 336; i++) cyc(i % 48 < 6, rnd(), rnd(), rnd());

    cur_req = "R6";  // deep overflow
    for (int i = 0; i < 100; i++) cyc(1'b1, rnd(), 1'b0, 1'b0);
    chk(trip_o, 1'b1, "R6", "deep overflow trip");

    cur_req = "R8";
    clr_req = 1'b1;
    for (int i = 0; i < 40; i++) cyc(i % 8 == 0, rnd(), 1'b0, 1'b0);
    chk(trip_o, 1'b0, "R8", "flag cleared");

    cur_req = "R9";  // shallow store, flush
    cyc(1'b0, 1'b0, 1'b0, 1'b0);
    cfg_deep = 1'b0;
    for (int i = 0; i < 200; i++) cyc(i % 8 == 0, rnd(), rnd(), rnd());

    cur_req = "R7";
    for (int i = 0; i < 40; i++) cyc(1'b1, rnd(), 1'b0, 1'b0);
    chk(trip_o, 1'b1, "R7", "shallow overflow trip");
    clr_req = 1'b1;
    for (int i = 0; i < 48; i++) cyc(i % 8 == 0, rnd(), 1'b0, 1'b0);
    chk(trip_o, 1'b0, "R8", "flag cleared again");
    for (int i = 0; i < 300; i++) cyc(1'b0, 1'b0, 1'b0, 1'b0);
    chk(trip_o, 1'b1, "R7", "shallow starvation trip");

    cur_req = "R2";  // transmit placement, gapped input
    clr_req = 1'b1;
    cyc(1'b0, 1'b0, 1'b0, 1'b0);
    cfg_place = 2'b10; cfg_deep = 1'b1;
    for (int i = 0; i < 240; i++) cyc(rnd(), rnd(), i % 24 < 3, rnd());

    cur_req = "R5";  // line standard change, no flush
    cyc(1'b0, 1'b0, 1'b0, 1'b0);
    cfg_e1 = 1'b1;
    for (int i = 0; i < 240; i++) cyc(rnd(), rnd(), i % 24 < 3, rnd());

    cur_req = "R10";  // bypass encodings
    clr_req = 1'b1;
    cyc(1'b0, 1'b0, 1'b0, 1'b0);
    cfg_place = 2'b00;
    for (int i = 0; i < 200; i++) cyc(rnd(), rnd(), rnd(), rnd());
    chk(trip_o, 1'b0, "R10", "no trip in bypass 00");
    cfg_place = 2'b11;
    for (int i = 0; i < 200; i++) cyc(rnd(), rnd(), rnd(), rnd());
    chk(trip_o, 1'b0, "R10", "no trip in bypass 11");

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule